// File: doc/BRIEF.md
# Key-Guarded Base Address Register

This block holds a 32-bit base address that software writes one byte at a time over a simple byte-addressed register bus. A separate 8-bit key register guards it. While the guard is engaged, every byte write aimed at the base register is dropped. Software opens the guard by storing the unlock value 0x59 in the key register. It can then rewrite the base register byte by byte. The write that lands on the most significant byte is accepted, and that same write closes the guard again.

Both registers can be read at any time. The bus is a plain single-cycle register port: a write strobe with an address and a data byte, and a combinational read path selected by an address. Because the port never stalls, it has no valid/ready handshake and no back-pressure. The 32-bit base value is also driven on an output so that downstream logic can use it.

Top module: `keyed_base_reg`

## Requirements
- R1: After reset the key register reads 0x00, the base register reads 0x00000000, and the guard is engaged (`unlocked_o` = 0).
- R2: A write of 0x59 to the key register (address 4) stores 0x59 and opens the guard on the next cycle (`unlocked_o` = 1).
- R3: A write of any value other than 0x59 to the key register changes nothing. The key register keeps its previous value and the guard state is unchanged.
- R4: While the guard is engaged, byte writes to addresses 0 to 3 leave the base register unchanged.
- R5: While the guard is open, a write to address n (n = 0 to 3) replaces bits [8n+7:8n] of the base register. The lower three bytes may be written any number of times and in any order without closing the guard.
- R6: While the guard is open, a write to address 3 (the most significant byte) is accepted and closes the guard on the same clock edge. The key register returns to 0x00.
- R7: Reads return the key register at address 4 and the 32-bit base register on `base_o`, whatever the guard state. The read data is combinational from `rd_addr_i`: address 0 to 3 gives the base byte and address 4 gives the key. Any other address gives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 3 | Write address: 0..3 base bytes, 4 key |
| wr_data_i | input | 8 | Write data byte |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data byte, combinational |
| base_o | output | 32 | Current base register value |
| unlocked_o | output | 1 | High while base writes are allowed |

## Verification
The bench writes key values next to 0x59, such as 0x58 and 0x5A. A comparator that ignored some bits would unlock on these. It also writes a wrong key after a valid one; a design that overwrote the stored key would relock here. It checks that the top-byte write both takes effect and relocks. A design that relocked first would lose that byte, and one that kept the guard open would accept a later write. It also writes the lower bytes repeatedly and out of order, which catches a design that relocks on any base write.

// File: rtl/keyed_base_pkg.sv
package keyed_base_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned N_BYTES  = 4;
  localparam int unsigned ADDR_W   = 3;
  localparam logic [BYTE_W-1:0] UNLOCK_KEY = 8'h59;
  localparam logic [ADDR_W-1:0] KEY_ADDR   = 3'd4;
  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/kb_key_guard.sv
module kb_key_guard
  import keyed_base_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_req_t           req_i,
  input  logic              top_write_i,
  output logic [BYTE_W-1:0] key_o,
  output logic              open_o
);
  logic [BYTE_W-1:0] key_q;
  logic key_hit;

  assign key_hit = req_i.en && (req_i.addr == KEY_ADDR) && (req_i.data == UNLOCK_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          key_q <= '0;
    else if (top_write_i) key_q <= '0;
    else if (key_hit)     key_q <= UNLOCK_KEY;
  end

  assign key_o  = key_q;
  assign open_o = (key_q == UNLOCK_KEY);

  AST_KEY_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_q == '0) || (key_q == UNLOCK_KEY)); // R3
  AST_BAD_KEY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.en && req_i.addr == KEY_ADDR && req_i.data != UNLOCK_KEY) |=> $stable(key_q)); // R3
  AST_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_write_i |=> (key_q == '0)); // R6
endmodule

// File: rtl/kb_base_bytes.sv
module kb_base_bytes
  import keyed_base_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  wr_req_t                   req_i,
  input  logic                      open_i,
  output logic                      top_write_o,
  output logic [N_BYTES*BYTE_W-1:0] base_o
);
  logic [N_BYTES-1:0] lane_we;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
    assign lane_we[g] = open_i && req_i.en && (req_i.addr == ADDR_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         base_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (lane_we[g]) base_o[g*BYTE_W +: BYTE_W] <= req_i.data;
    end
  end

  assign top_write_o = lane_we[N_BYTES-1];

  AST_LOCKED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> $stable(base_o)); // R4
  AST_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_we)); // R5
endmodule

// File: rtl/keyed_base_reg.sv
module keyed_base_reg
  import keyed_base_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic [2:0]  rd_addr_i,
  output logic [7:0]  rd_data_o,
  output logic [31:0] base_o,
  output logic        unlocked_o
);
  wr_req_t req;
  logic top_write;
  logic [BYTE_W-1:0] key;

  assign req = '{en: wr_en_i, addr: wr_addr_i, data: wr_data_i};

  kb_key_guard u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .top_write_i(top_write),
    .key_o(key), .open_o(unlocked_o)
  );

  kb_base_bytes u_bytes (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .open_i(unlocked_o),
    .top_write_o(top_write), .base_o(base_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == KEY_ADDR)
      rd_data_o = key;
    else if (rd_addr_i < ADDR_W'(N_BYTES))
      rd_data_o = base_o[rd_addr_i[1:0]*BYTE_W +: BYTE_W];
  end

  AST_TOP_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && wr_en_i && wr_addr_i == 3'd3) |=> (!unlocked_o && base_o[31:24] == $past(wr_data_i))); // R6
  AST_KEY_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == KEY_ADDR && wr_data_i == UNLOCK_KEY && !(unlocked_o && wr_addr_i == 3'd3)) |=> unlocked_o); // R2
endmodule

// File: tb/tb_keyed_base_reg.sv
module tb_keyed_base_reg;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [31:0] base;
  logic unlocked;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  keyed_base_reg dut (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .base_o(base), .unlocked_o(unlocked));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_key(string req, logic [7:0] exp);
    rd_addr = 3'd4; #1; chk(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic t_reset;
    rd_key("R1", 8'h00);
    chk("R1", base, 32'h0);
    chk("R1", {31'h0, unlocked}, 32'h0);
  endtask

  task automatic t_bad_keys;
    wr(4, 8'h58); chk("R3", {31'h0, unlocked}, 0); rd_key("R3", 8'h00);
    wr(4, 8'h5A); chk("R3", {31'h0, unlocked}, 0);
    wr(4, 8'hD9); chk("R3", {31'h0, unlocked}, 0);
  endtask

  task automatic t_locked_writes;
    for (int i = 0; i < 4; i++) wr(3'(i), 8'hA0 + 8'(i));
    chk("R4", base, 32'h0);
  endtask

  task automatic t_unlock_and_write;
    wr(4, 8'h59);
    chk("R2", {31'h0, unlocked}, 1); rd_key("R2", 8'h59);
    wr(4, 8'h11); chk("R3", {31'h0, unlocked}, 1); rd_key("R3", 8'h59);
    wr(2, 8'h33); wr(0, 8'h11); wr(1, 8'h22); wr(0, 8'h44);
    chk("R5", base, 32'h00332244);
    chk("R5", {31'h0, unlocked}, 1);
    for (int i = 0; i < 3; i++) begin
      rd_addr = 3'(i); #1;
      chk("R7", {24'h0, rd_data}, {24'h0, base[i*8 +: 8]});
    end
    wr(3, 8'hC5);
    chk("R6", base, 32'hC5332244);
    chk("R6", {31'h0, unlocked}, 0);
    rd_key("R6", 8'h00);
    wr(3, 8'hFF); wr(0, 8'hFF);
    chk("R4", base, 32'hC5332244);
    rd_addr = 3'd3; #1; chk("R7", {24'h0, rd_data}, 32'hC5);
    rd_addr = 3'd6; #1; chk("R7", {24'h0, rd_data}, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_bad_keys();
        t_locked_writes();
        t_unlock_and_write();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule